// File: doc/BRIEF.md
# DMA Channel Address Register with Auto-Increment

This block holds the 16-bit RAM address that one DMA channel reads from or writes to. Software loads a starting address over a CPU-side port, either as one 16-bit word or one byte half at a time. The same port always returns the stored value. While the channel runs, each one-cycle completion strobe from the channel moves the address forward by the element size: one in byte mode, two in word mode. After the last element, the register therefore points just past the final address.

In word mode the address sent to the datapath always has bit 0 cleared. The stored bit 0 is still returned on reads until the first step replaces it. CPU writes are refused while the channel is active, so software cannot corrupt a transfer in progress. The asynchronous reset is released through a small synchronizer inside the block.

Top module: `dma_addr_reg`

## Requirements
- R1: Reset clears the register. `cpu_rdata` and `dp_addr` read 0x0000 during reset and after it is released, until the first write or step.
- R2: In byte mode (`xfer_word` = 0), a `xfer_done` pulse with no accepted write makes the register equal its previous value plus 1 on the next cycle.
- R3: In word mode (`xfer_word` = 1), a `xfer_done` pulse with no accepted write makes the register equal its previous value with bit 0 cleared, plus 2.
- R4: In word mode, `dp_addr` equals the stored value with bit 0 forced to 0, while `cpu_rdata` still shows the stored bit 0. In byte mode, `dp_addr` equals the stored value.
- R5: A write is accepted when `cpu_wr_en` = 1, `xfer_active` = 0 and at least one lane enable is set. `cpu_be[0]` loads bits 7:0 from `cpu_wdata[7:0]` and `cpu_be[1]` loads bits 15:8 from `cpu_wdata[15:8]`. A lane that is not enabled keeps its old value.
- R6: While `xfer_active` = 1, a CPU write has no effect on the stored value. A `xfer_done` pulse in the same cycle still steps the address.
- R7: When an accepted write and `xfer_done` occur in the same cycle, the write result is stored and no step is applied.
- R8: Stepping wraps modulo 2^16. Byte mode 0xFFFF steps to 0x0000, and word mode 0xFFFE or 0xFFFF steps to 0x0000.
- R9: With no accepted write and no `xfer_done`, the stored value does not change. Reading has no side effects.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_wr_en | input | 1 | CPU write request |
| cpu_be | input | 2 | Byte-lane enables (bit 0 = low byte, bit 1 = high byte) |
| cpu_wdata | input | 16 | CPU write data |
| cpu_rdata | output | 16 | Stored register value |
| xfer_word | input | 1 | Transfer size: 0 = byte, 1 = word |
| xfer_active | input | 1 | Channel is transferring; blocks CPU writes |
| xfer_done | input | 1 | One-cycle strobe marking a completed element |
| dp_addr | output | 16 | Address presented to the datapath |

## Verification
Stepping is driven from both even and odd start addresses in each size mode. The odd start separates correct masking of bit 0 in word mode from a plain add of two. Byte-lane writes use each single lane and then both lanes, which shows whether an unselected half is preserved. Collision cases pair writes with strobes with the channel both idle and active, which separates write priority from write lockout. Runs that start at the top of the address range confirm the wrap to zero in both modes.

// File: rtl/dma_addr_pkg.sv
package dma_addr_pkg;
  typedef enum logic {
    XFER_BYTE = 1'b0,
    XFER_WORD = 1'b1
  } xfer_size_e;

  localparam int unsigned LANE_W = 8;
endpackage

// File: rtl/dma_addr_rst_sync.sv
module dma_addr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/dma_addr_lane_merge.sv
module dma_addr_lane_merge
  import dma_addr_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  localparam int unsigned NLANES = ADDR_W / LANE_W
) (
  input  logic [ADDR_W-1:0] cur_val,
  input  logic [ADDR_W-1:0] wr_data,
  input  logic [NLANES-1:0] lane_en,
  output logic [ADDR_W-1:0] merged
);
  for (genvar g = 0; g < NLANES; g++) begin : g_lane
    assign merged[g*LANE_W +: LANE_W] = lane_en[g] ? wr_data[g*LANE_W +: LANE_W]
                                                   : cur_val[g*LANE_W +: LANE_W];
  end
endmodule

// File: rtl/dma_addr_stepper.sv
module dma_addr_stepper
  import dma_addr_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] cur_val,
  input  xfer_size_e        size,
  output logic [ADDR_W-1:0] aligned,
  output logic [ADDR_W-1:0] stepped
);
  localparam logic [ADDR_W-1:0] BYTE_STEP = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] WORD_STEP = ADDR_W'(2);

  always_comb begin
    if (size == XFER_WORD) begin
      aligned = {cur_val[ADDR_W-1:1], 1'b0};
      stepped = aligned + WORD_STEP;
    end else begin
      aligned = cur_val;
      stepped = aligned + BYTE_STEP;
    end
  end
endmodule

// File: rtl/dma_addr_reg.sv
module dma_addr_reg
  import dma_addr_pkg::*;
#(
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned NLANES     = ADDR_W / LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_wr_en,
  input  logic [NLANES-1:0] cpu_be,
  input  logic [ADDR_W-1:0] cpu_wdata,
  output logic [ADDR_W-1:0] cpu_rdata,
  input  logic              xfer_word,
  input  logic              xfer_active,
  input  logic              xfer_done,
  output logic [ADDR_W-1:0] dp_addr
);
  logic              rst_sync_n;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [ADDR_W-1:0] merged, aligned, stepped;
  logic              wr_ok, addr_en;
  xfer_size_e        size;

  assign size = xfer_size_e'(xfer_word);

  dma_addr_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sync_n)
  );

  dma_addr_lane_merge #(.ADDR_W(ADDR_W)) u_merge (
    .cur_val (addr_q),
    .wr_data (cpu_wdata),
    .lane_en (cpu_be),
    .merged  (merged)
  );

  dma_addr_stepper #(.ADDR_W(ADDR_W)) u_step (
    .cur_val (addr_q),
    .size    (size),
    .aligned (aligned),
    .stepped (stepped)
  );

  // Next-state: an accepted CPU write takes priority over a step.
  always_comb begin
    wr_ok   = cpu_wr_en & ~xfer_active & (|cpu_be);
    addr_en = wr_ok | xfer_done;
    addr_d  = wr_ok ? merged : stepped;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  addr_q <= '0;
    else if (addr_en) addr_q <= addr_d;
  end

  assign cpu_rdata = addr_q;
  assign dp_addr   = aligned;
endmodule

// File: rtl/dma_addr_reg_chk.sv
module dma_addr_reg_chk #(
  parameter int unsigned ADDR_W = 16,
  localparam int unsigned NLANES = ADDR_W / 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_wr_en,
  input logic [NLANES-1:0] cpu_be,
  input logic [ADDR_W-1:0] cpu_wdata,
  input logic [ADDR_W-1:0] cpu_rdata,
  input logic              xfer_word,
  input logic              xfer_active,
  input logic              xfer_done,
  input logic [ADDR_W-1:0] dp_addr
);
  logic wr_acc;
  assign wr_acc = cpu_wr_en && !xfer_active && (cpu_be != '0);

  assert_byte_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_acc && xfer_done && !xfer_word) |=> cpu_rdata == $past(cpu_rdata) + ADDR_W'(1));

  assert_word_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_acc && xfer_done && xfer_word) |=>
      cpu_rdata == ({$past(cpu_rdata[ADDR_W-1:1]), 1'b0} + ADDR_W'(2)));

  assert_even_dp_R4: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_word |-> (dp_addr[0] == 1'b0 && dp_addr[ADDR_W-1:1] == cpu_rdata[ADDR_W-1:1]));

  assert_low_lane_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && cpu_be == 2'b01) |=>
      (cpu_rdata[7:0] == $past(cpu_wdata[7:0]) && cpu_rdata[15:8] == $past(cpu_rdata[15:8])));

  assert_lockout_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_active && !xfer_done) |=> $stable(cpu_rdata));

  assert_write_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && xfer_done && cpu_be == 2'b11) |=> cpu_rdata == $past(cpu_wdata));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_acc && !xfer_done) |=> $stable(cpu_rdata));
endmodule

bind dma_addr_reg dma_addr_reg_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .cpu_wr_en   (cpu_wr_en),
  .cpu_be      (cpu_be),
  .cpu_wdata   (cpu_wdata),
  .cpu_rdata   (cpu_rdata),
  .xfer_word   (xfer_word),
  .xfer_active (xfer_active),
  .xfer_done   (xfer_done),
  .dp_addr     (dp_addr)
);

// File: tb/tb_dma_addr_reg.sv
module tb_dma_addr_reg;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cpu_wr_en, xfer_word, xfer_active, xfer_done;
  logic [1:0]  cpu_be;
  logic [15:0] cpu_wdata, cpu_rdata, dp_addr;

  int tests = 0;
  int fails = 0;
  int model = 0;
  bit done_flag = 1'b0;

  always #4 clk = ~clk;

  dma_addr_reg dut (
    .clk(clk), .rst_n(rst_n), .cpu_wr_en(cpu_wr_en), .cpu_be(cpu_be),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .xfer_word(xfer_word),
    .xfer_active(xfer_active), .xfer_done(xfer_done), .dp_addr(dp_addr)
  );

  task automatic check(string req, int actual, int expected);
    tests++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, actual, expected);
    end
  endtask

  // Drive one cycle at a negedge, update the model at the edge, compare at the next negedge.
  task automatic cyc(string req, bit we, bit [1:0] be, int wd, bit word, bit act, bit dn);
    int nxt;
    cpu_wr_en = we; cpu_be = be; cpu_wdata = 16'(wd);
    xfer_word = word; xfer_active = act; xfer_done = dn;
    nxt = model;
    if (we && !act && be != 0) begin
      if (be[0]) nxt = (nxt / 256) * 256 + (wd % 256);
      if (be[1]) nxt = ((wd / 256) % 256) * 256 + (nxt % 256);
    end else if (dn) begin
      if (word) nxt = (model - (model % 2) + 2) % 65536;
      else      nxt = (model + 1) % 65536;
    end
    @(posedge clk);
    model = nxt;
    @(negedge clk);
    check(req, int'(cpu_rdata), model);
    check(req, int'(dp_addr), word ? model - (model % 2) : model);
  endtask

  initial begin
    #1000000;
    if (!done_flag) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    cpu_wr_en = 0; cpu_be = 0; cpu_wdata = 0; xfer_word = 0; xfer_active = 0; xfer_done = 0;
    repeat (3) @(negedge clk);
    check("R1", int'(cpu_rdata), 0);
    check("R1", int'(dp_addr), 0);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) cyc("R1", 0, 2'b00, 0, 0, 0, 0);

    // R5: byte lanes
    cyc("R5", 1, 2'b11, 16'hA55A, 0, 0, 0);
    cyc("R5", 1, 2'b01, 16'h00C3, 0, 0, 0);
    cyc("R5", 1, 2'b10, 16'h7E00, 0, 0, 0);
    cyc("R5", 1, 2'b00, 16'h1111, 0, 0, 0);
    // R9: idle hold
    for (int i = 0; i < 3; i++) cyc("R9", 0, 2'b00, 16'hFFFF, 0, 0, 0);
    // R2: byte stepping from odd start
    cyc("R2", 1, 2'b11, 16'h1235, 0, 0, 0);
    for (int i = 0; i < 4; i++) cyc("R2", 0, 2'b00, 0, 0, 1, 1);
    // R4/R3: word mode from odd start
    cyc("R4", 1, 2'b11, 16'h2001, 1, 0, 0);
    cyc("R4", 0, 2'b00, 0, 1, 1, 0);
    for (int i = 0; i < 3; i++) cyc("R3", 0, 2'b00, 0, 1, 1, 1);
    cyc("R3", 1, 2'b11, 16'h4000, 1, 0, 0);
    cyc("R3", 0, 2'b00, 0, 1, 1, 1);
    // R6: writes while active
    cyc("R6", 1, 2'b11, 16'hDEAD, 0, 1, 0);
    cyc("R6", 1, 2'b01, 16'h00EE, 0, 1, 1);
    cyc("R6", 1, 2'b11, 16'hBEEF, 1, 1, 1);
    // R7: write and strobe together while idle
    cyc("R7", 1, 2'b11, 16'h0100, 0, 0, 1);
    cyc("R7", 1, 2'b01, 16'h0077, 1, 0, 1);
    // R8: wrap
    cyc("R8", 1, 2'b11, 16'hFFFF, 0, 0, 0);
    cyc("R8", 0, 2'b00, 0, 0, 1, 1);
    cyc("R8", 1, 2'b11, 16'hFFFE, 1, 0, 0);
    cyc("R8", 0, 2'b00, 0, 1, 1, 1);
    cyc("R8", 1, 2'b11, 16'hFFFF, 1, 0, 0);
    cyc("R8", 0, 2'b00, 0, 1, 1, 1);
    cyc("R9", 0, 2'b00, 0, 1, 0, 0);

    done_flag = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule